// File: doc/BRIEF.md
# UART Modem Control and Loopback Unit

This block holds the modem control settings of a serial port and routes the port's lines according to them. Software writes one control byte. That byte sets the request-to-send and data-terminal-ready requests, two auxiliary outputs that have no pin of their own, and a loopback switch. From these settings the block drives the active-low request pins, the external serial output and the receive bit that goes to the receiver. It also supplies the four modem status lines that the status logic sees.

In normal operation the active-low external modem inputs pass through a two-flop synchroniser. In loopback the block ignores the external pins and forms a closed test path. The transmit bit goes straight to the receiver. The external serial output sits at its idle level, and both request pins are held inactive. Each control request feeds back as a modem input: RTS to CTS, DTR to DSR, first auxiliary to RI, and second auxiliary to DCD. Sticky change flags record input activity. A status read clears them.

Top module: `uart_modem_ctrl`

## Requirements
- R1: After reset the control byte reads 0x00, `rts_n` and `dtr_n` are high, all change flags are 0 and `txd` follows `tx_bit`.
- R2: A write stores bits 4:0 (bit 0 DTR request, bit 1 RTS request, bit 2 first auxiliary, bit 3 second auxiliary, bit 4 loopback). From the next cycle on, `ctl_rdata` returns them, and bits 7:5 always read 0.
- R3: With loopback off, `rts_n` is the inverse of control bit 1 and `dtr_n` is the inverse of control bit 0, in the cycle after the write.
- R4: With loopback on, `txd`, `rts_n` and `dtr_n` are all held at 1.
- R5: With loopback on, `rx_bit` equals `tx_bit` and `rxd` has no effect. With loopback off, `rx_bit` equals `rxd`.
- R6: `sts_rdata` bits 4,5,6,7 report CTS, DSR, RI and DCD as asserted (1 = active). With loopback off, each is the inverse of its pin, delayed by two clock edges. With loopback on, they come from control bits 1, 0, 2 and 3 respectively, starting the cycle after the write.
- R7: The change flags in `sts_rdata` bits 0 (CTS), 1 (DSR) and 3 (DCD) are set on the edge after the reported status bit changes in either direction. They stay set until cleared.
- R8: Flag bit 2 (RI) is set only when the reported RI goes from asserted to deasserted.
- R9: When `sts_rd` is high at an edge, all flags are cleared. A change detected at that same edge still sets its flag.
- R10: With loopback off, control bits 2 and 3 do not affect `rts_n`, `dtr_n`, `txd` or the reported modem status.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctl_wr | input | 1 | Control byte write strobe |
| ctl_wdata | input | 8 | Control byte write data |
| ctl_rdata | output | 8 | Stored control byte |
| sts_rd | input | 1 | Modem status read strobe, clears the flags |
| sts_rdata | output | 8 | Modem status: flags [3:0], asserted inputs [7:4] |
| tx_bit | input | 1 | Serial bit from the transmitter |
| txd | output | 1 | External serial output pin |
| rxd | input | 1 | External serial input pin |
| rx_bit | output | 1 | Serial bit delivered to the receiver |
| rts_n | output | 1 | Request-to-send pin, active low |
| dtr_n | output | 1 | Data-terminal-ready pin, active low |
| cts_n | input | 1 | Clear-to-send pin, active low |
| dsr_n | input | 1 | Data-set-ready pin, active low |
| ri_n | input | 1 | Ring indicator pin, active low |
| dcd_n | input | 1 | Carrier detect pin, active low |

## Verification
The assertions take three things for granted. Writes, reads and pin levels are stable around each rising edge. The write strobe is a clean single-cycle qualifier for its data. The external modem pins sit at their idle high level while reset is asserted, so the synchroniser's reset value matches them. The stimulus changes every input only at the falling edge, keeps the pins high during reset, and toggles the modem pins only now and then. That leaves each level long enough for the two-edge synchroniser latency to be observed. Directed sequences walk loopback on and off, give RI a rising and a trailing transition, and put a read on the same edge as a change. Seeded random traffic then mixes writes, reads and pin activity.

// File: rtl/uart_mc_pkg.sv
package uart_mc_pkg;

    localparam int CTL_USED_W = 5;
    localparam int MDM_N      = 4;

    localparam int CB_DTR  = 0;
    localparam int CB_RTS  = 1;
    localparam int CB_AUX1 = 2;
    localparam int CB_AUX2 = 3;
    localparam int CB_LOOP = 4;

    localparam int MI_CTS = 0;
    localparam int MI_DSR = 1;
    localparam int MI_RI  = 2;
    localparam int MI_DCD = 3;

    typedef struct packed {
        logic loop;
        logic aux2;
        logic aux1;
        logic rts;
        logic dtr;
    } mc_ctl_t;

endpackage

// File: rtl/mc_ctl_reg.sv
module mc_ctl_reg
    import uart_mc_pkg::*;
#(
    parameter int CTL_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr,
    input  logic [CTL_W-1:0] wdata,
    output mc_ctl_t          ctl,
    output logic [CTL_W-1:0] rdata
);
    localparam int PAD_W = CTL_W - CTL_USED_W;

    typedef struct packed {
        mc_ctl_t ctl;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr) begin
            st_d.ctl = mc_ctl_t'(wdata[CTL_USED_W-1:0]);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign ctl   = st_q.ctl;
    assign rdata = {{PAD_W{1'b0}}, st_q.ctl};

    // R2: written low bits come back, upper bits read as zero
    a_r2_store: assert property (@(posedge clk) disable iff (!rst_n)
        wr |=> rdata == {{PAD_W{1'b0}}, $past(wdata[CTL_USED_W-1:0])});

endmodule

// File: rtl/mc_sync.sv
module mc_sync #(
    parameter int               WIDTH   = 4,
    parameter int               STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);
    typedef logic [STAGES-1:0][WIDTH-1:0] chain_t;

    chain_t chain_d, chain_q;

    always_comb begin
        chain_d[0] = din;
        for (int i = 1; i < STAGES; i++) begin
            chain_d[i] = chain_q[i-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chain_q <= {STAGES{RST_VAL}};
        end else begin
            chain_q <= chain_d;
        end
    end

    assign dout = chain_q[STAGES-1];

endmodule

// File: rtl/mc_delta.sv
module mc_delta #(
    parameter int           N          = 4,
    parameter logic [N-1:0] TRAIL_MASK = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] sel,
    input  logic         clr,
    output logic [N-1:0] flags
);
    typedef struct packed {
        logic [N-1:0] prev;
        logic [N-1:0] flags;
    } st_t;

    st_t          st_d, st_q;
    logic [N-1:0] hit;

    for (genvar g = 0; g < N; g++) begin : g_bit
        if (TRAIL_MASK[g]) begin : g_trail
            assign hit[g] = st_q.prev[g] & ~sel[g];
            // R8: trailing-edge flag rises only after asserted -> deasserted
            a_r8_trail_only: assert property (@(posedge clk) disable iff (!rst_n)
                $rose(flags[g]) |-> ($past(st_q.prev[g]) && !$past(sel[g])));
        end else begin : g_any
            assign hit[g] = st_q.prev[g] ^ sel[g];
            // R7: change flag rises only after the input moved
            a_r7_edge_cause: assert property (@(posedge clk) disable iff (!rst_n)
                $rose(flags[g]) |-> ($past(st_q.prev[g]) != $past(sel[g])));
        end
    end

    always_comb begin
        st_d.prev  = sel;
        st_d.flags = (clr ? '0 : st_q.flags) | hit;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign flags = st_q.flags;

    // R7: flags are sticky without a read
    a_r7_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        !clr |=> ((flags & $past(flags)) == $past(flags)));

    // R9: a read with no concurrent change empties the flags
    a_r9_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && (sel == st_q.prev)) |=> (flags == '0));

endmodule

// File: rtl/uart_modem_ctrl.sv
module uart_modem_ctrl
    import uart_mc_pkg::*;
#(
    parameter int CTL_W       = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ctl_wr,
    input  logic [CTL_W-1:0] ctl_wdata,
    output logic [CTL_W-1:0] ctl_rdata,
    input  logic             sts_rd,
    output logic [2*MDM_N-1:0] sts_rdata,
    input  logic             tx_bit,
    output logic             txd,
    input  logic             rxd,
    output logic             rx_bit,
    output logic             rts_n,
    output logic             dtr_n,
    input  logic             cts_n,
    input  logic             dsr_n,
    input  logic             ri_n,
    input  logic             dcd_n
);
    localparam logic [MDM_N-1:0] TRAIL = MDM_N'(1) << MI_RI;

    mc_ctl_t          ctl;
    logic [MDM_N-1:0] pin_raw;
    logic [MDM_N-1:0] pin_sync;
    logic [MDM_N-1:0] loop_vec;
    logic [MDM_N-1:0] sel;
    logic [MDM_N-1:0] flags;

    mc_ctl_reg #(.CTL_W(CTL_W)) u_ctl (
        .clk   (clk),
        .rst_n (rst_n),
        .wr    (ctl_wr),
        .wdata (ctl_wdata),
        .ctl   (ctl),
        .rdata (ctl_rdata)
    );

    always_comb begin
        pin_raw         = '1;
        pin_raw[MI_CTS] = cts_n;
        pin_raw[MI_DSR] = dsr_n;
        pin_raw[MI_RI]  = ri_n;
        pin_raw[MI_DCD] = dcd_n;
    end

    mc_sync #(.WIDTH(MDM_N), .STAGES(SYNC_STAGES), .RST_VAL('1)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (pin_raw),
        .dout  (pin_sync)
    );

    always_comb begin
        loop_vec         = '0;
        loop_vec[MI_CTS] = ctl.rts;
        loop_vec[MI_DSR] = ctl.dtr;
        loop_vec[MI_RI]  = ctl.aux1;
        loop_vec[MI_DCD] = ctl.aux2;
        sel    = ctl.loop ? loop_vec : ~pin_sync;
        txd    = ctl.loop ? 1'b1 : tx_bit;
        rx_bit = ctl.loop ? tx_bit : rxd;
        rts_n  = ctl.loop ? 1'b1 : ~ctl.rts;
        dtr_n  = ctl.loop ? 1'b1 : ~ctl.dtr;
    end

    mc_delta #(.N(MDM_N), .TRAIL_MASK(TRAIL)) u_delta (
        .clk   (clk),
        .rst_n (rst_n),
        .sel   (sel),
        .clr   (sts_rd),
        .flags (flags)
    );

    assign sts_rdata = {sel, flags};

    // R3: request pins take the inverted written bits
    a_r3_rts_pol: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_wr && !ctl_wdata[CB_LOOP]) |=> (rts_n == !$past(ctl_wdata[CB_RTS])));
    a_r3_dtr_pol: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_wr && !ctl_wdata[CB_LOOP]) |=> (dtr_n == !$past(ctl_wdata[CB_DTR])));

    // R4: loopback parks the external outputs
    a_r4_loop_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_wr && ctl_wdata[CB_LOOP]) |=> (txd && rts_n && dtr_n));

    // R5: loopback feeds the transmit bit to the receiver
    a_r5_rx_loop: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_wr && ctl_wdata[CB_LOOP]) |=> (rx_bit == tx_bit));

    // R6: loopback cross-connects the control requests to the status inputs
    a_r6_loop_cross: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_wr && ctl_wdata[CB_LOOP]) |=>
        (sts_rdata[2*MDM_N-1:MDM_N] == {$past(ctl_wdata[CB_AUX2]), $past(ctl_wdata[CB_AUX1]),
                                        $past(ctl_wdata[CB_DTR]), $past(ctl_wdata[CB_RTS])}));

endmodule

// File: tb/uart_modem_ctrl_tb.sv
`timescale 1ns/1ps
module uart_modem_ctrl_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ctl_wr = 1'b0;
    logic [7:0] ctl_wdata = '0;
    logic [7:0] ctl_rdata;
    logic       sts_rd = 1'b0;
    logic [7:0] sts_rdata;
    logic       tx_bit = 1'b1;
    logic       txd;
    logic       rxd = 1'b1;
    logic       rx_bit;
    logic       rts_n, dtr_n;
    logic       cts_n = 1'b1, dsr_n = 1'b1, ri_n = 1'b1, dcd_n = 1'b1;

    int n_chk  = 0;
    int n_fail = 0;

    always #2 clk = ~clk;

    uart_modem_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata),
        .ctl_rdata(ctl_rdata), .sts_rd(sts_rd), .sts_rdata(sts_rdata),
        .tx_bit(tx_bit), .txd(txd), .rxd(rxd), .rx_bit(rx_bit),
        .rts_n(rts_n), .dtr_n(dtr_n), .cts_n(cts_n), .dsr_n(dsr_n),
        .ri_n(ri_n), .dcd_n(dcd_n)
    );

    // Reference state kept from the requirements
    logic [7:0] m_ctl   = '0;
    logic [3:0] m_s1    = '0;
    logic [3:0] m_s2    = '0;
    logic [3:0] m_prev  = '0;
    logic [3:0] m_flags = '0;
    logic       m_rd    = 1'b0;

    function automatic logic [3:0] exp_sel(input logic [7:0] c, input logic [3:0] ext);
        // status order: [0] CTS, [1] DSR, [2] RI, [3] DCD
        return c[4] ? {c[3], c[2], c[0], c[1]} : ext;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_ctl = '0; m_s1 = '0; m_s2 = '0; m_prev = '0; m_flags = '0; m_rd = 1'b0;
        end else begin
            logic [3:0] s, d;
            s = exp_sel(m_ctl, m_s2);
            d = s ^ m_prev;
            d[2] = m_prev[2] & ~s[2];
            m_flags = (sts_rd ? 4'b0 : m_flags) | d;
            m_rd   = sts_rd;
            m_prev = s;
            m_s2   = m_s1;
            m_s1   = ~{dcd_n, ri_n, dsr_n, cts_n};
            if (ctl_wr) m_ctl = ctl_wdata & 8'h1F;
        end
    end

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic check_all();
        logic       lp;
        logic [3:0] s;
        lp = m_ctl[4];
        s  = exp_sel(m_ctl, m_s2);
        chk("R2 control readback", ctl_rdata, m_ctl);
        chk(lp ? "R4 request pins parked" : "R3 request pin polarity",
            {6'b0, rts_n, dtr_n}, lp ? 8'h03 : {6'b0, ~m_ctl[1], ~m_ctl[0]});
        chk("R4 serial output", {7'b0, txd}, {7'b0, lp ? 1'b1 : tx_bit});
        chk("R5 receive path", {7'b0, rx_bit}, {7'b0, lp ? tx_bit : rxd});
        chk("R6 modem status", {4'b0, sts_rdata[7:4]}, {4'b0, s});
        chk("R7 change flags", {5'b0, sts_rdata[3], sts_rdata[1:0]},
            {5'b0, m_flags[3], m_flags[1:0]});
        chk("R8 trailing ring flag", {7'b0, sts_rdata[2]}, {7'b0, m_flags[2]});
        if (m_rd) chk("R9 flags after read", {4'b0, sts_rdata[3:0]}, {4'b0, m_flags});
        if (!lp && m_ctl[3:2] != 2'b00)
            chk("R10 aux bits inert", {4'b0, rts_n, dtr_n, sts_rdata[6], sts_rdata[7]},
                {4'b0, ~m_ctl[1], ~m_ctl[0], m_s2[2], m_s2[3]});
    endtask

    task automatic cyc(input logic wr, input logic [7:0] wd, input logic rd);
        ctl_wr = wr; ctl_wdata = wd; sts_rd = rd;
        @(negedge clk);
        check_all();
        ctl_wr = 1'b0; sts_rd = 1'b0;
    endtask

    initial begin
        int seed;
        seed = $urandom(32'd7741);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 reset control", ctl_rdata, 8'h00);
        chk("R1 reset pins", {5'b0, rts_n, dtr_n, txd}, {5'b0, 1'b1, 1'b1, tx_bit});
        chk("R1 reset flags", {4'b0, sts_rdata[3:0]}, 8'h00);
        // directed corners
        cyc(1, 8'hFF, 0);          // R2 reserved bits dropped, loopback on
        cyc(0, 8'h00, 0);
        tx_bit = 1'b0; rxd = 1'b1;
        cyc(0, 8'h00, 0);          // R5 loop path
        cyc(1, 8'h10, 1);          // R8 RI trailing in loopback, read same edge
        cyc(0, 8'h00, 0);
        cyc(1, 8'h14, 1);          // RI rising: no flag bit 2
        cyc(0, 8'h00, 1);
        cyc(0, 8'h00, 0);
        cyc(1, 8'h0E, 0);          // R10 aux bits with loopback off
        cyc(0, 8'h00, 0);
        ri_n = 1'b0; dcd_n = 1'b0;
        repeat (4) cyc(0, 8'h00, 0);
        cyc(0, 8'h00, 1);          // R9 read clears
        ri_n = 1'b1;
        repeat (4) cyc(0, 8'h00, 0);
        cyc(1, 8'h02, 0);          // R3 RTS only
        cyc(1, 8'h01, 0);          // R3 DTR only
        // seeded random traffic
        for (int i = 0; i < 3000; i++) begin
            tx_bit = 1'($urandom);
            rxd    = 1'($urandom);
            if ($urandom_range(7) == 0) cts_n = ~cts_n;
            if ($urandom_range(7) == 0) dsr_n = ~dsr_n;
            if ($urandom_range(7) == 0) ri_n  = ~ri_n;
            if ($urandom_range(7) == 0) dcd_n = ~dcd_n;
            cyc($urandom_range(4) == 0, 8'($urandom), $urandom_range(5) == 0);
        end
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        #(200000 * 4);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule